// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a multi-cycle processor, built as a microcode store read through a small microprogram counter rather than as a hand-written next-state function. Each microaddress selects one microinstruction. A microinstruction holds every datapath strobe and mux select, plus a 2-bit sequencing field that picks where the counter goes next.

The counter has four possible next values: zero, its own value plus one, or an entry from one of two lookup tables indexed by the instruction opcode. The microcode and both lookup tables are constants computed inside the block. The control outputs depend on the microaddress alone. Their values equal those of the equivalent hardwired state machine, so the two can be compared cycle by cycle.

The surrounding processor feeds the opcode field of its instruction register into the block. It uses the control outputs to steer its program counter, memory, register file and ALU.

Top module: `micro_sequencer`

## Requirements
- R1: While `rstN` is low the microaddress is 0. The outputs then carry the fetch word: memRead=1, irWrite=1, pcWrite=1, aluSrcB=01, and every other output 0.
- R2: Microaddress 0 is always followed by microaddress 1, whatever the opcode.
- R3: At microaddress 1 the next address comes from the first opcode table: opcode 0 (register format) gives 6, opcode 2 (jump) gives 9, opcode 4 (branch-equal) gives 8, and opcodes 35 (load) and 43 (store) both give 2.
- R4: At microaddress 2 the next address comes from the second opcode table: opcode 35 gives 3 and opcode 43 gives 5.
- R5: An opcode missing from the table in use at microaddress 1 or 2 sends the counter to 0.
- R6: Microaddresses 3 and 6 are each followed by their value plus one (4 and 7), whatever the opcode.
- R7: Microaddresses 4, 5, 7, 8 and 9 are followed by 0, whatever the opcode.
- R8: The ALU controls per microaddress are as follows. aluOp is 00 (add) except at 6, where it is 10 (function field), and at 8, where it is 01 (subtract). aluSrcA is 1 at 2, 6 and 8 and 0 elsewhere. aluSrcB is 01 (constant 4) at 0, 11 (shifted immediate) at 1, 10 (immediate) at 2, and 00 elsewhere.
- R9: The memory and register strobes are as follows. memRead is high at 0 and 3, and irWrite at 0. memWrite is high at 5. iOrD is 1 at 3 and 5. regWrite is high at 4 and 7. regDst is 1 at 7 and memToReg is 1 at 4. All of these are 0 elsewhere.
- R10: The program-counter controls are as follows. pcWrite with pcSource=00 at 0. pcWriteCond with pcSource=01 at 8. pcWrite with pcSource=10 at 9. pcWrite and pcWriteCond are never high together and are 0 elsewhere.
- R11: After reset the microaddress never exceeds 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opcode | input | OP_W (6) | Opcode field of the instruction register |
| uAddr | output | UADDR_W (4) | Current microaddress |
| pcWrite | output | 1 | Unconditional program-counter write |
| pcWriteCond | output | 1 | Program-counter write qualified by ALU zero |
| iOrD | output | 1 | Memory address select: 0 program counter, 1 ALU result register |
| memRead | output | 1 | Memory read strobe |
| memWrite | output | 1 | Memory write strobe |
| irWrite | output | 1 | Instruction register load |
| memToReg | output | 1 | Register write data: 0 ALU result, 1 memory data register |
| pcSource | output | 2 | Next program counter select: 00 ALU, 01 ALU result register, 10 jump target |
| aluOp | output | 2 | 00 add, 01 subtract, 10 from function field |
| aluSrcA | output | 1 | ALU A operand: 0 program counter, 1 register A |
| aluSrcB | output | 2 | ALU B operand: 00 register B, 01 constant 4, 10 immediate, 11 shifted immediate |
| regWrite | output | 1 | Register file write strobe |
| regDst | output | 1 | Destination register: 0 rt field, 1 rd field |

## Verification
The bench builds the block with its defaults: a 4-bit microaddress and a 6-bit opcode. At these widths all sixteen microcode words and all 64 opcode values fit in a small run. The random phase draws opcodes from the full 6-bit space and changes them every cycle. This reaches table misses at both dispatch points, including a load or store that turns into an unknown opcode between the two dispatches. It also shows that the opcode is ignored at every microaddress that does not dispatch.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [1:0] {
    SEL_ZERO  = 2'b00,
    SEL_DISP1 = 2'b01,
    SEL_DISP2 = 2'b10,
    SEL_NEXT  = 2'b11
  } addrSel_e;

  typedef struct packed {
    logic       pcWrite;
    logic       pcWriteCond;
    logic [1:0] pcSource;
    logic       iOrD;
    logic       memRead;
    logic       memWrite;
    logic       irWrite;
    logic       memToReg;
    logic       regWrite;
    logic       regDst;
    logic [1:0] aluOp;
    logic       aluSrcA;
    logic [1:0] aluSrcB;
  } ctrlWord_t;

  typedef struct packed {
    ctrlWord_t ctrl;
    addrSel_e  seq;
  } microInst_t;

  // microaddresses whose positions the dispatch tables and sequencing rely on
  localparam int UA_FETCH  = 0;
  localparam int UA_DECODE = 1;
  localparam int UA_ADRCMP = 2;
  localparam int UA_LOAD   = 3;
  localparam int UA_LDWB   = 4;
  localparam int UA_STORE  = 5;
  localparam int UA_EXEC   = 6;
  localparam int UA_RWB    = 7;
  localparam int UA_BRANCH = 8;
  localparam int UA_JUMP   = 9;
  localparam int UA_LAST   = UA_JUMP;

  localparam logic [1:0] ALU_ADD  = 2'b00;
  localparam logic [1:0] ALU_SUB  = 2'b01;
  localparam logic [1:0] ALU_FUNC = 2'b10;

  localparam logic [1:0] SRCB_REG   = 2'b00;
  localparam logic [1:0] SRCB_FOUR  = 2'b01;
  localparam logic [1:0] SRCB_IMM   = 2'b10;
  localparam logic [1:0] SRCB_IMMSH = 2'b11;

  localparam logic [1:0] PCSRC_ALU  = 2'b00;
  localparam logic [1:0] PCSRC_HELD = 2'b01;
  localparam logic [1:0] PCSRC_JMP  = 2'b10;

  function automatic microInst_t ucodeAt(input int addr);
    microInst_t w;
    w     = '0;
    w.seq = SEL_ZERO;
    case (addr)
      UA_FETCH: begin
        w.ctrl.memRead  = 1'b1;
        w.ctrl.irWrite  = 1'b1;
        w.ctrl.aluSrcB  = SRCB_FOUR;
        w.ctrl.aluOp    = ALU_ADD;
        w.ctrl.pcSource = PCSRC_ALU;
        w.ctrl.pcWrite  = 1'b1;
        w.seq           = SEL_NEXT;
      end
      UA_DECODE: begin
        w.ctrl.aluSrcB = SRCB_IMMSH;
        w.ctrl.aluOp   = ALU_ADD;
        w.seq          = SEL_DISP1;
      end
      UA_ADRCMP: begin
        w.ctrl.aluSrcA = 1'b1;
        w.ctrl.aluSrcB = SRCB_IMM;
        w.ctrl.aluOp   = ALU_ADD;
        w.seq          = SEL_DISP2;
      end
      UA_LOAD: begin
        w.ctrl.memRead = 1'b1;
        w.ctrl.iOrD    = 1'b1;
        w.seq          = SEL_NEXT;
      end
      UA_LDWB: begin
        w.ctrl.regWrite = 1'b1;
        w.ctrl.memToReg = 1'b1;
      end
      UA_STORE: begin
        w.ctrl.memWrite = 1'b1;
        w.ctrl.iOrD     = 1'b1;
      end
      UA_EXEC: begin
        w.ctrl.aluSrcA = 1'b1;
        w.ctrl.aluSrcB = SRCB_REG;
        w.ctrl.aluOp   = ALU_FUNC;
        w.seq          = SEL_NEXT;
      end
      UA_RWB: begin
        w.ctrl.regWrite = 1'b1;
        w.ctrl.regDst   = 1'b1;
      end
      UA_BRANCH: begin
        w.ctrl.aluSrcA     = 1'b1;
        w.ctrl.aluSrcB     = SRCB_REG;
        w.ctrl.aluOp       = ALU_SUB;
        w.ctrl.pcSource    = PCSRC_HELD;
        w.ctrl.pcWriteCond = 1'b1;
      end
      UA_JUMP: begin
        w.ctrl.pcSource = PCSRC_JMP;
        w.ctrl.pcWrite  = 1'b1;
      end
      default: ;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
#(
  parameter int UADDR_W = 4
) (
  input  logic [UADDR_W-1:0] uAddr,
  output ctrlWord_t          ctrl,
  output addrSel_e           addrSel
);
  localparam int DEPTH = 1 << UADDR_W;

  microInst_t romArr [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign romArr[i] = ucodeAt(i);
  end

  microInst_t curWord;
  assign curWord = romArr[uAddr];
  assign ctrl    = curWord.ctrl;
  assign addrSel = curWord.seq;
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int OP_W    = 6,
  parameter int UADDR_W = 4,
  parameter int OP_RFMT = 0,
  parameter int OP_JMP  = 2,
  parameter int OP_BEQ  = 4,
  parameter int OP_LD   = 35,
  parameter int OP_ST   = 43
) (
  input  logic [OP_W-1:0]    opcode,
  output logic [UADDR_W-1:0] disp1Addr,
  output logic [UADDR_W-1:0] disp2Addr
);
  localparam int NOPS = 1 << OP_W;

  logic [UADDR_W-1:0] tbl1 [NOPS];
  logic [UADDR_W-1:0] tbl2 [NOPS];

  for (genvar i = 0; i < NOPS; i++) begin : g_tbl
    if (i == OP_RFMT) begin : g_r
      assign tbl1[i] = UADDR_W'(UA_EXEC);
      assign tbl2[i] = '0;
    end else if (i == OP_JMP) begin : g_j
      assign tbl1[i] = UADDR_W'(UA_JUMP);
      assign tbl2[i] = '0;
    end else if (i == OP_BEQ) begin : g_b
      assign tbl1[i] = UADDR_W'(UA_BRANCH);
      assign tbl2[i] = '0;
    end else if (i == OP_LD) begin : g_l
      assign tbl1[i] = UADDR_W'(UA_ADRCMP);
      assign tbl2[i] = UADDR_W'(UA_LOAD);
    end else if (i == OP_ST) begin : g_s
      assign tbl1[i] = UADDR_W'(UA_ADRCMP);
      assign tbl2[i] = UADDR_W'(UA_STORE);
    end else begin : g_miss
      assign tbl1[i] = '0;
      assign tbl2[i] = '0;
    end
  end

  assign disp1Addr = tbl1[opcode];
  assign disp2Addr = tbl2[opcode];
endmodule

// File: rtl/useq_addr.sv
module useq_addr
  import useq_pkg::*;
#(
  parameter int OP_W    = 6,
  parameter int UADDR_W = 4,
  parameter int OP_RFMT = 0,
  parameter int OP_JMP  = 2,
  parameter int OP_BEQ  = 4,
  parameter int OP_LD   = 35,
  parameter int OP_ST   = 43
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [OP_W-1:0]    opcode,
  input  addrSel_e           addrSel,
  output logic [UADDR_W-1:0] uAddr
);
  logic [UADDR_W-1:0] disp1Addr;
  logic [UADDR_W-1:0] disp2Addr;
  logic [UADDR_W-1:0] nextAddr;

  useq_dispatch #(
    .OP_W(OP_W), .UADDR_W(UADDR_W), .OP_RFMT(OP_RFMT), .OP_JMP(OP_JMP),
    .OP_BEQ(OP_BEQ), .OP_LD(OP_LD), .OP_ST(OP_ST)
  ) dispatch_i (
    .opcode(opcode),
    .disp1Addr(disp1Addr),
    .disp2Addr(disp2Addr)
  );

  always_comb begin
    case (addrSel)
      SEL_NEXT:  nextAddr = uAddr + UADDR_W'(1);
      SEL_DISP1: nextAddr = disp1Addr;
      SEL_DISP2: nextAddr = disp2Addr;
      default:   nextAddr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) uAddr <= '0;
    else       uAddr <= nextAddr;
  end

  logic knownOp1;
  logic knownOp2;
  assign knownOp1 = (opcode == OP_W'(OP_RFMT)) || (opcode == OP_W'(OP_JMP)) ||
                    (opcode == OP_W'(OP_BEQ))  || (opcode == OP_W'(OP_LD))  ||
                    (opcode == OP_W'(OP_ST));
  assign knownOp2 = (opcode == OP_W'(OP_LD)) || (opcode == OP_W'(OP_ST));

  assert_fetch_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    uAddr == UADDR_W'(UA_FETCH) |=> uAddr == UADDR_W'(UA_DECODE));
  assert_disp1_jump_R3: assert property (@(posedge clk) disable iff (!rstN)
    (uAddr == UADDR_W'(UA_DECODE) && opcode == OP_W'(OP_JMP)) |=> uAddr == UADDR_W'(UA_JUMP));
  assert_disp2_store_R4: assert property (@(posedge clk) disable iff (!rstN)
    (uAddr == UADDR_W'(UA_ADRCMP) && opcode == OP_W'(OP_ST)) |=> uAddr == UADDR_W'(UA_STORE));
  assert_disp1_miss_R5: assert property (@(posedge clk) disable iff (!rstN)
    (uAddr == UADDR_W'(UA_DECODE) && !knownOp1) |=> uAddr == '0);
  assert_disp2_miss_R5: assert property (@(posedge clk) disable iff (!rstN)
    (uAddr == UADDR_W'(UA_ADRCMP) && !knownOp2) |=> uAddr == '0);
  assert_incr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (uAddr == UADDR_W'(UA_LOAD) || uAddr == UADDR_W'(UA_EXEC)) |=> uAddr == $past(uAddr) + UADDR_W'(1));
  assert_return_R7: assert property (@(posedge clk) disable iff (!rstN)
    (uAddr == UADDR_W'(UA_LDWB) || uAddr == UADDR_W'(UA_STORE) || uAddr == UADDR_W'(UA_RWB) ||
     uAddr == UADDR_W'(UA_BRANCH) || uAddr == UADDR_W'(UA_JUMP)) |=> uAddr == '0);
  assert_in_range_R11: assert property (@(posedge clk) disable iff (!rstN)
    uAddr <= UADDR_W'(UA_LAST));
endmodule

// File: rtl/micro_sequencer.sv
module micro_sequencer
  import useq_pkg::*;
#(
  parameter int OP_W    = 6,
  parameter int UADDR_W = 4,
  parameter int OP_RFMT = 0,
  parameter int OP_JMP  = 2,
  parameter int OP_BEQ  = 4,
  parameter int OP_LD   = 35,
  parameter int OP_ST   = 43
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [OP_W-1:0]    opcode,
  output logic [UADDR_W-1:0] uAddr,
  output logic               pcWrite,
  output logic               pcWriteCond,
  output logic               iOrD,
  output logic               memRead,
  output logic               memWrite,
  output logic               irWrite,
  output logic               memToReg,
  output logic [1:0]         pcSource,
  output logic [1:0]         aluOp,
  output logic               aluSrcA,
  output logic [1:0]         aluSrcB,
  output logic               regWrite,
  output logic               regDst
);
  ctrlWord_t ctrl;
  addrSel_e  addrSel;

  useq_store #(.UADDR_W(UADDR_W)) store_i (
    .uAddr(uAddr),
    .ctrl(ctrl),
    .addrSel(addrSel)
  );

  useq_addr #(
    .OP_W(OP_W), .UADDR_W(UADDR_W), .OP_RFMT(OP_RFMT), .OP_JMP(OP_JMP),
    .OP_BEQ(OP_BEQ), .OP_LD(OP_LD), .OP_ST(OP_ST)
  ) addr_i (
    .clk(clk),
    .rstN(rstN),
    .opcode(opcode),
    .addrSel(addrSel),
    .uAddr(uAddr)
  );

  assign pcWrite     = ctrl.pcWrite;
  assign pcWriteCond = ctrl.pcWriteCond;
  assign iOrD        = ctrl.iOrD;
  assign memRead     = ctrl.memRead;
  assign memWrite    = ctrl.memWrite;
  assign irWrite     = ctrl.irWrite;
  assign memToReg    = ctrl.memToReg;
  assign pcSource    = ctrl.pcSource;
  assign aluOp       = ctrl.aluOp;
  assign aluSrcA     = ctrl.aluSrcA;
  assign aluSrcB     = ctrl.aluSrcB;
  assign regWrite    = ctrl.regWrite;
  assign regDst      = ctrl.regDst;

  assert_alu_code_R8: assert property (@(posedge clk) disable iff (!rstN)
    aluOp != 2'b11);
  assert_mem_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memRead, memWrite}));
  assert_ir_on_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    irWrite |-> (memRead && !iOrD));
  assert_pc_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pcWrite, pcWriteCond}));
  assert_cond_src_R10: assert property (@(posedge clk) disable iff (!rstN)
    pcWriteCond |-> pcSource == 2'b01);
endmodule

// File: tb/micro_sequencer_tb_top.sv
`timescale 1ns/1ps
module micro_sequencer_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] opcode = 6'd0;
  logic [3:0] uAddr;
  logic pcWrite, pcWriteCond, iOrD, memRead, memWrite, irWrite, memToReg;
  logic [1:0] pcSource, aluOp, aluSrcB;
  logic aluSrcA, regWrite, regDst;

  int numChecks = 0;
  int numFail   = 0;
  bit running   = 1'b0;
  bit finished  = 1'b0;

  always #4 clk = ~clk;

  micro_sequencer dut_i (
    .clk(clk), .rstN(rstN), .opcode(opcode), .uAddr(uAddr),
    .pcWrite(pcWrite), .pcWriteCond(pcWriteCond), .iOrD(iOrD),
    .memRead(memRead), .memWrite(memWrite), .irWrite(irWrite),
    .memToReg(memToReg), .pcSource(pcSource), .aluOp(aluOp),
    .aluSrcA(aluSrcA), .aluSrcB(aluSrcB), .regWrite(regWrite), .regDst(regDst)
  );

  // behavioural reference, written from the requirement list
  function automatic int refNext(int s, int op);
    case (s)
      0: return 1;
      1: begin
        if (op == 0) return 6;
        if (op == 2) return 9;
        if (op == 4) return 8;
        if (op == 35 || op == 43) return 2;
        return 0;
      end
      2: begin
        if (op == 35) return 3;
        if (op == 43) return 5;
        return 0;
      end
      3: return 4;
      6: return 7;
      default: return 0;
    endcase
  endfunction

  // {aluSrcA, aluSrcB, aluOp}
  function automatic logic [4:0] refAlu(int s);
    case (s)
      0: return {1'b0, 2'b01, 2'b00};
      1: return {1'b0, 2'b11, 2'b00};
      2: return {1'b1, 2'b10, 2'b00};
      6: return {1'b1, 2'b00, 2'b10};
      8: return {1'b1, 2'b00, 2'b01};
      default: return 5'd0;
    endcase
  endfunction

  // {memRead, memWrite, iOrD, irWrite, regWrite, regDst, memToReg}
  function automatic logic [6:0] refMem(int s);
    case (s)
      0: return 7'b1001000;
      3: return 7'b1010000;
      4: return 7'b0000101;
      5: return 7'b0110000;
      7: return 7'b0000110;
      default: return 7'd0;
    endcase
  endfunction

  // {pcWrite, pcWriteCond, pcSource}
  function automatic logic [3:0] refPc(int s);
    case (s)
      0: return 4'b1000;
      8: return 4'b0101;
      9: return 4'b1010;
      default: return 4'd0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    numChecks++;
    if (act !== exp) begin
      numFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", numChecks - numFail, numChecks);
      $finish;
    end
  endtask

  int refState = 0;
  int prevState = 0;
  int edgeOp = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      refState <= 0;
      prevState <= 0;
    end else begin
      prevState <= refState;
      edgeOp    <= int'(opcode);
      refState  <= refNext(refState, int'(opcode));
    end
  end

  function automatic string stepTag(int p, int op);
    if (p == 0) return "R2";
    if (p == 1) return (op == 0 || op == 2 || op == 4 || op == 35 || op == 43) ? "R3" : "R5";
    if (p == 2) return (op == 35 || op == 43) ? "R4" : "R5";
    if (p == 3 || p == 6) return "R6";
    return "R7";
  endfunction

  always @(negedge clk) begin
    if (running && rstN) begin
      chk(stepTag(prevState, edgeOp), 32'(uAddr), 32'(refState));
      chk("R11", 32'(uAddr <= 4'd9), 32'd1);
      chk("R8", 32'({aluSrcA, aluSrcB, aluOp}), 32'(refAlu(refState)));
      chk("R9", 32'({memRead, memWrite, iOrD, irWrite, regWrite, regDst, memToReg}),
          32'(refMem(refState)));
      chk("R10", 32'({pcWrite, pcWriteCond, pcSource}), 32'(refPc(refState)));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    numChecks++;
    numFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  localparam int NPROG = 8;
  int prog [NPROG] = '{0, 35, 43, 4, 2, 63, 8, 15};
  int pool [8]     = '{0, 2, 4, 35, 43, 63, 8, 15};

  initial begin
    rstN = 1'b0;
    opcode = 6'd35;
    repeat (3) @(negedge clk);
    // R1: reset state, fetch word
    chk("R1", 32'(uAddr), 32'd0);
    chk("R1", 32'({aluSrcA, aluSrcB, aluOp}), 32'(refAlu(0)));
    chk("R1", 32'({memRead, memWrite, iOrD, irWrite, regWrite, regDst, memToReg}), 32'(refMem(0)));
    chk("R1", 32'({pcWrite, pcWriteCond, pcSource}), 32'(refPc(0)));
    rstN = 1'b1;
    running = 1'b1;
    // directed: each opcode held across a complete instruction
    for (int i = 0; i < NPROG; i++) begin
      opcode = 6'(prog[i]);
      repeat (6) @(negedge clk);
    end
    // load that changes to an unknown code between the two dispatches
    opcode = 6'd35;
    repeat (2) @(negedge clk);
    opcode = 6'd63;
    repeat (4) @(negedge clk);
    // random: opcode changes every cycle
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if ($urandom_range(1, 0) == 0) opcode = 6'(pool[$urandom_range(7, 0)]);
      else                           opcode = 6'($urandom_range(63, 0));
    end
    @(negedge clk);
    running = 1'b0;
    summary();
  end
endmodule